// File: doc/BRIEF.md
# ADC FIFO Interrupt Status Controller

This block sits next to a sample FIFO of conversion results. It turns occupancy and acquisition events into one interrupt request line. A host writes a single control word to do three things: pick which general event may interrupt, enable that event and the end-of-acquisition event separately, and fire clear commands. A status word returns the sticky event flags, an overflow flag and a live FIFO-not-empty indication.

The FIFO reports its fill level and a push strobe. The block derives its not-empty, half-full and overrun conditions from these. Each latched flag sets on the rising edge of its condition and stays set until the host clears it. Clear bits are one-shot, so the host never has to write them back to zero. When a clear and a new event arrive in the same cycle, the event takes precedence, so no event is lost.

Top module: `ism_irq_status`

## Requirements
- R1: Reset (synchronous, active low) clears every latched flag, the source selection and both enables. After reset, status bits 0, 1, 2, 3 and 5 read 0 and `irq` is 0. The status word layout is: bit 0 end-of-acquisition latch, bit 1 general latch, bit 2 half-full latch, bit 3 not-empty latch, bit 4 live not-empty, bit 5 overflow latch.
- R2: The control word layout is: bits [1:0] general source select, bit 2 general enable, bit 3 end-of-acquisition enable, bit 4 clear end-of-acquisition, bit 5 clear general, bit 6 clear overflow. Bits [3:0] are held until the next write. With source code 01, a rising edge on `scan_done` sets the general latch.
- R3: With source code 10, the general latch sets when the fill level rises above DEPTH/2. A fill of 513 qualifies and a fill of 512 does not.
- R4: With source code 11, the general latch sets when the fill level rises from 0 to any non-zero value.
- R5: With source code 00, no event ever sets the general latch.
- R6: `irq` is 1 exactly when (general latch and general enable) or (end-of-acquisition latch and its enable). A cleared enable masks `irq`, but the latch stays visible in the status word.
- R7: A rising edge on `acq_done` sets the end-of-acquisition latch.
- R8: Writing a 1 to a clear bit clears its latch one cycle later. Writing a 0 to a clear bit leaves the latch unchanged. A later event sets the latch again without any release write.
- R9: If a set event and the clear for the same latch occur in the same cycle, the latch ends up set.
- R10: The half-full and not-empty latches set on the rising edges of their conditions whatever source is selected. The general clear bit clears them too.
- R11: Status bit 4 follows `fifo_fill != 0` in the same cycle, with no register in the path.
- R12: A push while the fill level equals DEPTH sets the overflow latch. A push at DEPTH-1 does not. The latch holds until the overflow clear bit is written.
- R13: A level that stays high sets its latch only once. After a clear, the latch stays 0 until the level falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word (layout in R2) |
| fifo_fill | input | FILL_W (11) | Current FIFO fill level, 0 to DEPTH |
| fifo_push | input | 1 | FIFO write attempt this cycle |
| scan_done | input | 1 | End of channel scan |
| acq_done | input | 1 | End of acquisition |
| irq | output | 1 | Interrupt request |
| status | output | 6 | Status word (layout in R1) |

## Verification
Every latched status bit and `irq` change on the first rising clock edge after the stimulus is presented. This holds whether the stimulus is a level, a push or a control write. The bench therefore drives on a falling edge and compares on the next falling edge, exactly one register later.

The live not-empty bit has no register in its path. It is checked a nanosecond after the fill level changes, before any edge occurs. Boundary rows sit at fills of 512/513 and 1023/1024, and some rows place a clear and an event in the same cycle.

// File: rtl/ism_pkg.sv
// Shared types and index constants for the interrupt status controller.
// Assumes: control word fields in the order given by ctl_word_t (LSB = src).
package ism_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_SCAN   = 2'b01,
        SRC_HALF   = 2'b10,
        SRC_NEMPTY = 2'b11
    } gsrc_e;

    typedef struct packed {
        logic  clr_ovf;
        logic  clr_gen;
        logic  clr_eoa;
        logic  eoa_en;
        logic  gen_en;
        gsrc_e src;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    // Latch bank indices
    localparam int LT_EOA    = 0;
    localparam int LT_GEN    = 1;
    localparam int LT_HF     = 2;
    localparam int LT_NE     = 3;
    localparam int LT_OVF    = 4;
    localparam int NUM_LATCH = 5;

    // Status word bit positions
    localparam int ST_EOA  = 0;
    localparam int ST_GEN  = 1;
    localparam int ST_HF   = 2;
    localparam int ST_NE   = 3;
    localparam int ST_LIVE = 4;
    localparam int ST_OVF  = 5;
    localparam int ST_W    = 6;

    // Raw level inputs to the rise detector
    localparam int LV_SCAN = 0;
    localparam int LV_HF   = 1;
    localparam int LV_NE   = 2;
    localparam int LV_ACQ  = 3;
    localparam int NUM_LV  = 4;

endpackage

// File: rtl/ism_fill_flags.sv
// Derives occupancy conditions from the FIFO fill level and push strobe.
// Assumes: fifo_fill never exceeds DEPTH; a push at DEPTH is an overrun.
module ism_fill_flags #(
    parameter int DEPTH  = 1024,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic [FILL_W-1:0] fill,
    input  logic              push,
    output logic              not_empty,
    output logic              half_full,
    output logic              overrun
);
    localparam logic [FILL_W-1:0] HALF_MARK = FILL_W'(DEPTH / 2);
    localparam logic [FILL_W-1:0] FULL_MARK = FILL_W'(DEPTH);

    // Purpose: compare fill level against the empty, half and full marks.
    always_comb begin
        not_empty = (fill != '0);
        half_full = (fill > HALF_MARK);
        overrun   = push && (fill >= FULL_MARK);
    end
endmodule

// File: rtl/ism_rise_det.sv
// Registers a vector of levels and flags each 0-to-1 transition for one cycle.
// Assumes: levels are synchronous to clk; history resets to 0.
module ism_rise_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Purpose: remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Purpose: mark levels that are high now but were low last cycle.
    always_comb rise = lvl & ~prev_q;

    // R13: a held level produces no second pulse
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/ism_sticky_bank.sv
// Bank of sticky flags: each bit sets on its set pulse, clears on its clear
// pulse, and set takes precedence when both arrive in one cycle.
module ism_sticky_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: hold one flag with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end

        // R9: a set in the same cycle as a clear leaves the flag set
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
        // R8: a clear with no set drops the flag
        a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !q[i]);
        // R13: a set flag persists while nothing clears it
        a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr[i]) |=> q[i]);
    end
endmodule

// File: rtl/ism_ctl_reg.sv
// Holds the persistent control fields and turns clear bits into one-cycle
// pulses that need no release write.
module ism_ctl_reg
    import ism_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output gsrc_e            src,
    output logic             gen_en,
    output logic             eoa_en,
    output logic             clr_eoa,
    output logic             clr_gen,
    output logic             clr_ovf
);
    ctl_word_t w;

    // Purpose: view the write data as a control word.
    always_comb w = ctl_word_t'(wdata);

    // Purpose: store source select and enables on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src    <= SRC_NONE;
            gen_en <= 1'b0;
            eoa_en <= 1'b0;
        end else if (wr) begin
            src    <= w.src;
            gen_en <= w.gen_en;
            eoa_en <= w.eoa_en;
        end
    end

    // Purpose: clear commands exist only in the write cycle.
    always_comb begin
        clr_eoa = wr && w.clr_eoa;
        clr_gen = wr && w.clr_gen;
        clr_ovf = wr && w.clr_ovf;
    end

    // R2: fields persist between writes
    a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(src) && $stable(gen_en) && $stable(eoa_en)));
endmodule

// File: rtl/ism_irq_status.sv
// ADC FIFO interrupt status controller (top).
// Combines FIFO occupancy, scan and acquisition events into sticky flags,
// a status word and one interrupt request.
// Assumes: all inputs synchronous to clk; fifo_fill in 0..DEPTH.
module ism_irq_status
    import ism_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [6:0]        ctl_wdata,
    input  logic [FILL_W-1:0] fifo_fill,
    input  logic              fifo_push,
    input  logic              scan_done,
    input  logic              acq_done,
    output logic              irq,
    output logic [5:0]        status
);
    localparam logic [ST_W-1:0] LATCH_MASK = ~(ST_W'(1) << ST_LIVE);
    localparam logic [FILL_W-1:0] FULL_MARK = FILL_W'(DEPTH);

    gsrc_e                 src;
    logic                  gen_en, eoa_en;
    logic                  clr_eoa, clr_gen, clr_ovf;
    logic                  ne_lvl, hf_lvl, overrun;
    logic [NUM_LV-1:0]     lvl, rise;
    logic                  gen_evt;
    logic [NUM_LATCH-1:0]  set_v, clr_v, lat;

    ism_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctl_wr),
        .wdata   (ctl_wdata),
        .src     (src),
        .gen_en  (gen_en),
        .eoa_en  (eoa_en),
        .clr_eoa (clr_eoa),
        .clr_gen (clr_gen),
        .clr_ovf (clr_ovf)
    );

    ism_fill_flags #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_fill (
        .fill      (fifo_fill),
        .push      (fifo_push),
        .not_empty (ne_lvl),
        .half_full (hf_lvl),
        .overrun   (overrun)
    );

    // Purpose: gather the levels whose rising edges matter.
    always_comb begin
        lvl          = '0;
        lvl[LV_SCAN] = scan_done;
        lvl[LV_HF]   = hf_lvl;
        lvl[LV_NE]   = ne_lvl;
        lvl[LV_ACQ]  = acq_done;
    end

    ism_rise_det #(.N(NUM_LV)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise)
    );

    // Purpose: route the selected source's edge to the general latch.
    always_comb begin
        unique case (src)
            SRC_SCAN:   gen_evt = rise[LV_SCAN];
            SRC_HALF:   gen_evt = rise[LV_HF];
            SRC_NEMPTY: gen_evt = rise[LV_NE];
            default:    gen_evt = 1'b0;
        endcase
    end

    // Purpose: map events and clear pulses onto the latch bank.
    always_comb begin
        set_v         = '0;
        clr_v         = '0;
        set_v[LT_EOA] = rise[LV_ACQ];
        set_v[LT_GEN] = gen_evt;
        set_v[LT_HF]  = rise[LV_HF];
        set_v[LT_NE]  = rise[LV_NE];
        set_v[LT_OVF] = overrun;
        clr_v[LT_EOA] = clr_eoa;
        clr_v[LT_GEN] = clr_gen;
        clr_v[LT_HF]  = clr_gen;
        clr_v[LT_NE]  = clr_gen;
        clr_v[LT_OVF] = clr_ovf;
    end

    ism_sticky_bank #(.N(NUM_LATCH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .q     (lat)
    );

    // Purpose: assemble the status word and the interrupt request.
    always_comb begin
        status          = '0;
        status[ST_EOA]  = lat[LT_EOA];
        status[ST_GEN]  = lat[LT_GEN];
        status[ST_HF]   = lat[LT_HF];
        status[ST_NE]   = lat[LT_NE];
        status[ST_LIVE] = ne_lvl;
        status[ST_OVF]  = lat[LT_OVF];
        irq = (lat[LT_GEN] && gen_en) || (lat[LT_EOA] && eoa_en);
    end

    // R1: reset leaves every latched flag and irq at 0
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (((status & LATCH_MASK) == '0) && !irq));
    // R5: with no source chosen the general flag never rises
    a_r5_none_no_gen: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE && !status[ST_GEN]) |=> !status[ST_GEN]);
    // R6: irq is only raised by a flag that is present
    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[ST_GEN] || status[ST_EOA]));
    // R7: an acquisition edge sets the end-of-acquisition flag
    a_r7_eoa_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_done) |=> status[ST_EOA]);
    // R2: scan edge with scan source selected sets the general flag
    a_r2_scan_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_SCAN && $rose(scan_done)) |=> status[ST_GEN]);
    // R12: a push at full sets the overflow flag
    a_r12_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_fill == FULL_MARK) |=> status[ST_OVF]);
endmodule

// File: tb/ism_irq_status_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module ism_irq_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [6:0]  ctl_wdata = '0;
    logic [10:0] fifo_fill = '0;
    logic        fifo_push = 1'b0;
    logic        scan_done = 1'b0;
    logic        acq_done = 1'b0;
    logic        irq;
    logic [5:0]  status;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ism_irq_status dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .fifo_fill (fifo_fill),
        .fifo_push (fifo_push),
        .scan_done (scan_done),
        .acq_done  (acq_done),
        .irq       (irq),
        .status    (status)
    );

    // Row: {wr, wdata[6:0], fill[10:0], push, scan, acq, exp_status[5:0], exp_irq}
    localparam int NV = 30;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1,7'h0D,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0}, // R2 src=scan, both enables
        {1'b0,7'h00,11'd0,   1'b0,1'b1,1'b0,6'h02,1'b1}, // R2 R6 scan edge
        {1'b0,7'h00,11'd0,   1'b0,1'b1,1'b0,6'h02,1'b1}, // R13 held
        {1'b1,7'h2D,11'd0,   1'b0,1'b1,1'b0,6'h00,1'b0}, // R8 R13 clear while high
        {1'b0,7'h00,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0},
        {1'b0,7'h00,11'd0,   1'b0,1'b1,1'b0,6'h02,1'b1}, // R8 no release write
        {1'b1,7'h2D,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0},
        {1'b1,7'h2D,11'd0,   1'b0,1'b1,1'b0,6'h02,1'b1}, // R9 set beats clear
        {1'b1,7'h09,11'd0,   1'b0,1'b0,1'b0,6'h02,1'b0}, // R6 mask, R8 zero no effect
        {1'b1,7'h2D,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0},
        {1'b0,7'h00,11'd0,   1'b0,1'b0,1'b1,6'h01,1'b1}, // R7 acq edge
        {1'b1,7'h1D,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0}, // R8 clear eoa
        {1'b1,7'h06,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0}, // R3 src=half
        {1'b0,7'h00,11'd1,   1'b0,1'b0,1'b0,6'h18,1'b0}, // R10 ne latch, R11 live
        {1'b0,7'h00,11'd512, 1'b0,1'b0,1'b0,6'h18,1'b0}, // R3 512 not half
        {1'b0,7'h00,11'd513, 1'b0,1'b0,1'b0,6'h1E,1'b1}, // R3 513 half
        {1'b0,7'h00,11'd600, 1'b0,1'b0,1'b0,6'h1E,1'b1},
        {1'b1,7'h26,11'd600, 1'b0,1'b0,1'b0,6'h10,1'b0}, // R10 general clear
        {1'b0,7'h00,11'd100, 1'b0,1'b0,1'b0,6'h10,1'b0},
        {1'b1,7'h07,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0}, // R4 src=not empty
        {1'b0,7'h00,11'd5,   1'b0,1'b0,1'b0,6'h1A,1'b1}, // R4 edge
        {1'b1,7'h27,11'd5,   1'b0,1'b0,1'b0,6'h10,1'b0},
        {1'b1,7'h04,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0}, // R5 src=none
        {1'b0,7'h00,11'd700, 1'b0,1'b0,1'b0,6'h1C,1'b0}, // R5 R10
        {1'b0,7'h00,11'd700, 1'b0,1'b1,1'b0,6'h1C,1'b0}, // R5 scan ignored
        {1'b0,7'h00,11'd1024,1'b1,1'b0,1'b0,6'h3C,1'b0}, // R12 push at full
        {1'b0,7'h00,11'd1000,1'b0,1'b0,1'b0,6'h3C,1'b0}, // R12 held
        {1'b1,7'h44,11'd1000,1'b0,1'b0,1'b0,6'h1C,1'b0}, // R8 R12 clear ovf
        {1'b0,7'h00,11'd1023,1'b1,1'b0,1'b0,6'h1C,1'b0}, // R12 push at 1023
        {1'b1,7'h24,11'd0,   1'b0,1'b0,1'b0,6'h00,1'b0}
    };

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic wr, input logic [6:0] wd, input logic [10:0] fill,
                         input logic push, input logic scan, input logic acq);
        ctl_wr    = wr;
        ctl_wdata = wd;
        fifo_fill = fill;
        fifo_push = push;
        scan_done = scan;
        acq_done  = acq;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state while and after reset
        check("R1 status", {1'b0, status}, 7'h00);
        check("R1 irq", {6'b0, irq}, 7'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-release", {irq, status}, 7'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][28], VEC[i][27:21], VEC[i][20:10], VEC[i][9], VEC[i][8], VEC[i][7]);
            @(negedge clk);
            check($sformatf("vector %0d status", i), {1'b0, status}, {1'b0, VEC[i][6:1]});
            check($sformatf("vector %0d irq", i), {6'b0, irq}, {6'b0, VEC[i][0]});
        end

        // R11 live flag with no clock edge in between
        drive(1'b0, 7'h00, 11'd3, 1'b0, 1'b0, 1'b0);
        #1;
        check("R11 live high", {6'b0, status[4]}, 7'h01);
        fifo_fill = 11'd0;
        #1;
        check("R11 live low", {6'b0, status[4]}, 7'h00);

        // R9 R12 push at full together with overflow clear
        @(negedge clk);
        drive(1'b1, 7'h40, 11'd1024, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 R12 ovf set wins", {irq, status}, 7'h3C);
        drive(1'b1, 7'h60, 11'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 R10 clear gen and ovf", {irq, status}, 7'h00);

        // R1 mid-run reset clears flags and control
        drive(1'b1, 7'h08, 11'd0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R7 eoa before reset", {irq, status}, 7'h41);
        drive(1'b0, 7'h00, 11'd0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {irq, status}, 7'h00);
        rst_n = 1'b1;
        scan_done = 1'b1;
        @(negedge clk);
        check("R1 R5 source reset to none", {irq, status}, 7'h00);
        acq_done = 1'b1;
        @(negedge clk);
        check("R1 R6 enable reset", {irq, status}, 7'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule